// File: doc/BRIEF.md
# Split-Access Accumulator Register

This block holds one 64-bit accumulator. A host or debug agent can write it as a whole word, or write either 32-bit half on its own. A half write merges the new half into the stored value, so the other half is left as it was. Storage always keeps all 64 written bits exactly.

The read side presents the accumulator as a 56-bit signed quantity. Bit 55 is copied into bits 63:56 of the full-width read value. The two 32-bit read outputs are the upper and lower halves of that sign-extended value. Reads are combinational from the stored register, so a write that lands on a rising edge is visible right after that edge.

Top module: `split_acc`

## Requirements
- R1: After reset the stored value is zero, so `rd_data`, `rd_hi` and `rd_lo` all read zero.
- R2: With `full_we` high at a rising edge, all 64 bits of `full_wdata` are stored unchanged. From the next edge on, `rd_data[55:0]` equals `full_wdata[55:0]`.
- R3: Bits 63:56 of `rd_data` are always copies of stored bit 55, whatever bits 63:56 of the stored word hold.
- R4: With `lo_we` high and `full_we` low, stored bits 31:0 take `lo_wdata` and stored bits 63:32 keep their value.
- R5: With `hi_we` high and `full_we` low, stored bits 63:32 take `hi_wdata` and stored bits 31:0 keep their value.
- R6: When `full_we` is high in the same cycle as `lo_we` or `hi_we`, the full write alone takes effect.
- R7: `rd_hi` equals `rd_data[63:32]` and `rd_lo` equals `rd_data[31:0]`.
- R8: When `lo_we` and `hi_we` are both high and `full_we` is low, both halves are replaced in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| full_we | input | 1 | Whole-word write enable |
| full_wdata | input | 64 | Whole-word write value |
| lo_we | input | 1 | Lower-half write enable |
| lo_wdata | input | 32 | Lower-half write value |
| hi_we | input | 1 | Upper-half write enable |
| hi_wdata | input | 32 | Upper-half write value |
| rd_data | output | 64 | Sign-extended accumulator value |
| rd_hi | output | 32 | Upper half of the sign-extended value |
| rd_lo | output | 32 | Lower half of the sign-extended value |

## Verification
A merge that damages the half it should keep appears on the read outputs at the first sample after the write edge, as long as the damaged bits are in 55:0. The bench therefore writes one half and then compares the other half against a reference. Damage confined to stored bits 63:56 has no effect on the outputs until a later write moves those bits into view, and by construction no write does. So the raw-storage properties are guarded by assertions on the stored word. Wrong sign extension appears at once for any value whose bit 55 is set. The stimulus includes writes that set bits 63:56 against bit 55, so that the masking step cannot be skipped without a mismatch.

// File: rtl/split_acc_pkg.sv
package split_acc_pkg;
  localparam int ACC_W  = 64;
  localparam int HALF_W = ACC_W / 2;
  localparam int SIGN_W = 56;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [HALF_W-1:0] half_t;

  // Sign-extend the low SIGN_W bits of a raw word to the full width.
  function automatic acc_t sext_view(input acc_t raw);
    acc_t r;
    for (int i = 0; i < ACC_W; i++)
      r[i] = (i < SIGN_W) ? raw[i] : raw[SIGN_W-1];
    return r;
  endfunction

  // Apply the half writes to a stored word. Each enabled half is replaced
  // and each half that is not enabled is carried over.
  function automatic acc_t merge_halves(input acc_t cur, input logic lo_en,
                                        input half_t lo_v, input logic hi_en,
                                        input half_t hi_v);
    acc_t r;
    r = cur;
    if (lo_en) r[HALF_W-1:0]     = lo_v;
    if (hi_en) r[ACC_W-1:HALF_W] = hi_v;
    return r;
  endfunction
endpackage

// File: rtl/split_acc_store.sv
module split_acc_store
  import split_acc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  full_we,
  input  acc_t  full_wdata,
  input  logic  lo_we,
  input  half_t lo_wdata,
  input  logic  hi_we,
  input  half_t hi_wdata,
  output acc_t  raw_q
);
  logic merge_ev;
  acc_t next_raw;

  assign merge_ev = !full_we && (lo_we || hi_we);

  always_comb begin
    if (full_we)       next_raw = full_wdata;
    else if (merge_ev) next_raw = merge_halves(raw_q, lo_we, lo_wdata, hi_we, hi_wdata);
    else               next_raw = raw_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= next_raw;
  end

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> raw_q == '0);
  p_full_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_we |=> raw_q == $past(full_wdata));
  p_lo_keeps_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we && !full_we) |=> $stable(raw_q[ACC_W-1:HALF_W]));
  p_hi_keeps_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !lo_we && !full_we) |=> $stable(raw_q[HALF_W-1:0]));
  p_both_halves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && lo_we && !full_we) |=> raw_q == {$past(hi_wdata), $past(lo_wdata)});
endmodule

// File: rtl/split_acc_view.sv
module split_acc_view
  import split_acc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  acc_t  raw_q,
  output acc_t  ext_q,
  output half_t ext_hi,
  output half_t ext_lo
);
  assign ext_q  = sext_view(raw_q);
  assign ext_hi = ext_q[ACC_W-1:HALF_W];
  assign ext_lo = ext_q[HALF_W-1:0];

  p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q[ACC_W-1:SIGN_W] == {(ACC_W-SIGN_W){raw_q[SIGN_W-1]}});
  p_low_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q[SIGN_W-1:0] == raw_q[SIGN_W-1:0]);
endmodule

// File: rtl/split_acc.sv
module split_acc
  import split_acc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        full_we,
  input  logic [63:0] full_wdata,
  input  logic        lo_we,
  input  logic [31:0] lo_wdata,
  input  logic        hi_we,
  input  logic [31:0] hi_wdata,
  output logic [63:0] rd_data,
  output logic [31:0] rd_hi,
  output logic [31:0] rd_lo
);
  acc_t raw_q;

  split_acc_store u_store (
    .clk(clk), .rst_n(rst_n),
    .full_we(full_we), .full_wdata(full_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_we(hi_we), .hi_wdata(hi_wdata),
    .raw_q(raw_q)
  );

  split_acc_view u_view (
    .clk(clk), .rst_n(rst_n), .raw_q(raw_q),
    .ext_q(rd_data), .ext_hi(rd_hi), .ext_lo(rd_lo)
  );

  p_full_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_we && (lo_we || hi_we)) |=> rd_data[55:0] == $past(full_wdata[55:0]));
  p_halves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    {rd_hi, rd_lo} == rd_data);
endmodule

// File: tb/split_acc_bench.sv
module split_acc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_we, lo_we, hi_we;
  logic [63:0] full_wdata;
  logic [31:0] lo_wdata, hi_wdata;
  logic [63:0] rd_data;
  logic [31:0] rd_hi, rd_lo;

  int n_cmp = 0;
  int n_bad = 0;
  longint unsigned model = 0;

  always #5 clk = ~clk;

  split_acc u_split_acc (
    .clk(clk), .rst_n(rst_n),
    .full_we(full_we), .full_wdata(full_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_we(hi_we), .hi_wdata(hi_wdata),
    .rd_data(rd_data), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  // Reference arithmetic: mask to 56 bits, flip the sign bit, subtract it.
  function automatic longint unsigned ref_ext(input longint unsigned v);
    longint unsigned sb;
    sb = 64'h0080_0000_0000_0000;
    return ((v & 64'h00FF_FFFF_FFFF_FFFF) ^ sb) - sb;
  endfunction

  task automatic compare(input string tag);
    longint unsigned e;
    e = ref_ext(model);
    n_cmp++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, e);
    end
    n_cmp++;
    if (rd_hi !== e[63:32] || rd_lo !== e[31:0]) begin
      n_bad++;
      $display("FAIL R7 %s halves act=%h_%h exp=%h", tag, rd_hi, rd_lo, e);
    end
  endtask

  // Drive at the falling edge, let the rising edge store, check at the next falling edge.
  task automatic step(input logic fw, input longint unsigned fd, input logic lw,
                      input int unsigned ld, input logic hw, input int unsigned hd,
                      input string tag);
    full_we = fw; full_wdata = fd; lo_we = lw; lo_wdata = ld; hi_we = hw; hi_wdata = hd;
    @(posedge clk);
    if (fw) model = fd;
    else begin
      if (lw) model = {model[63:32], ld};
      if (hw) model = {hd, model[31:0]};
    end
    @(negedge clk);
    full_we = 0; lo_we = 0; hi_we = 0;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired act=hang exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; full_we = 0; lo_we = 0; hi_we = 0;
    full_wdata = 0; lo_wdata = 0; hi_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    model = 0;
    compare("R1 reset");
    step(1, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, 0, "R2 full positive");
    step(1, 64'h00F0_0000_0000_0001, 0, 0, 0, 0, "R3 bit55 set");
    step(1, 64'hA500_0000_1111_2222, 0, 0, 0, 0, "R3 junk top clear");
    step(1, 64'h5A80_0000_0000_0000, 0, 0, 0, 0, "R3 junk top set");
    step(0, 0, 1, 32'hDEAD_BEEF, 0, 0, "R4 low write");
    step(0, 0, 0, 0, 1, 32'h0012_3456, "R5 high write");
    step(0, 0, 0, 0, 1, 32'hFF80_0001, "R5 high write sign");
    step(0, 0, 1, 32'h0000_0001, 0, 0, "R4 low keeps negative");
    step(1, 64'h0000_0000_CAFE_F00D, 1, 32'h1, 1, 32'h2, "R6 full beats both");
    step(1, 64'h0011_2233_4455_6677, 1, 32'h9, 0, 0, "R6 full beats low");
    step(0, 0, 1, 32'h7777_8888, 1, 32'h4480_0000, "R8 both halves");
    // Stored top byte kept across a low write: remains masked on read.
    step(1, 64'hFF00_0000_0000_0000, 0, 0, 0, 0, "R2 top byte only");
    step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R4 low under junk top");
    for (int i = 0; i < 400; i++) begin
      int unsigned sel;
      sel = $urandom % 8;
      step(sel[0], {$urandom, $urandom}, sel[1], $urandom, sel[2], $urandom, "R2 R4 R5 random");
    end
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; model = 0;
    compare("R1 re-reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule